// File: doc/BRIEF.md
# Four-Channel PWM Register Block

This block gives software control of four pulse-width channels through a small word-addressed register bus. A shared group of registers starts and stops channels, reports which channels are running, and collects the event raised each time a channel begins a new period. Every channel also has its own window of registers. These hold its prescaler and output polarity, its compare and period values, and shadow copies of the compare and period values that take effect only at a period boundary.

Starting and stopping use separate write-only masks, so one store can change any subset of channels without a read-modify-write. A stop request takes effect only when the running period completes. The running status therefore lags the write that asked for the stop. Period-start events collect in one flag register that empties when it is read. A single level interrupt follows that register.

Top module: `pwm_regblk`

## Requirements
- R1: A write to 0x04 starts channel i (0..3) for each wdata bit i that is 1 and that channel is stopped. Its counter restarts from zero, and bit i of the status register at 0x0C reads 1 on the next cycle. Zero bits have no effect, and a 1 for a running channel has no effect.
- R2: A write to 0x08 with bit i set requests a stop of channel i, and zero bits have no effect. Status bit i stays 1 until the period in progress completes, and only then clears.
- R3: Each period start of a running channel sets flag bit i in the event register at 0x1C. A start through 0x04 also counts as a period start. A read of 0x1C returns bits [3:0] of the flags and clears them all.
- R4: A flag whose event arrives in the same cycle as a read of 0x1C stays set after that read.
- R5: Output `irq_o` is high exactly while any event flag is set.
- R6: Channel i has a window at 0x200 + 0x20*i. Its registers are: mode at +0x00 (prescale code in bits [3:0], polarity in bit 9, all other bits read 0), compare at +0x04, compare shadow at +0x08, period at +0x0C and period shadow at +0x10. Compare and period values are 16 bits wide.
- R7: A shadow write leaves the live compare or period unchanged until the channel's next period start. At that start the shadow value is copied into the live register.
- R8: A running channel counts 0 to period-1 once every 2^p clocks, where p is the prescale code clamped to 10. Its output is at the inactive level while count < compare and at the active level otherwise. With polarity 0 the inactive level is 0, and polarity 1 inverts the output. A stopped channel outputs its inactive level.
- R9: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses include unaligned ones, the space between the global registers and 0x200, unused window offsets, and everything from 0x280 up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, acts on the clock edge |
| re_i | input | 1 | Read strobe; read side effects act on the clock edge |
| rdata_o | output | 32 | Read data, valid during the read cycle |
| irq_o | output | 1 | Level interrupt, high while any event flag is set |
| pwm_o | output | 4 | Channel outputs |

## Verification
A vector table drives every mapped register with all-ones and out-of-range data, and then reads back. The readback shows field masking and truncation to 16 bits. It also separates true holes and the window just past the last channel from aliased channel registers. Directed runs then tell apart several behaviours:
- A fast channel with two prescale codes, distinguished by counting output edges.
- Two polarities at the same compare value, distinguished by counting high samples over whole periods.
- A stop written mid-period, against one that takes effect at once.
- A slow channel where the shadow values must stay hidden until its boundary.
- A channel that raises an event on every clock, so that a clear-on-read that drops a coincident event shows up on the very next read.

// File: rtl/pwm_regblk.sv
module pwm_regblk #(
  parameter int NCH     = 4,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int CW      = 16,
  parameter int MAXPRE  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic [NCH-1:0] pwm_o
);
  localparam logic [AW-1:0] A_START  = AW'('h04);
  localparam logic [AW-1:0] A_STOP   = AW'('h08);
  localparam logic [AW-1:0] A_STAT   = AW'('h0C);
  localparam logic [AW-1:0] A_EVT    = AW'('h1C);
  localparam int            WIN_SH   = 5;
  localparam logic [AW-1:0] WIN_BASE = AW'('h200);
  localparam logic [AW-1:0] WIN_END  = AW'('h200 + (NCH << WIN_SH));
  localparam int            IW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int            PW       = MAXPRE;
  localparam logic [4:0] O_MODE = 5'h00, O_CMP = 5'h04, O_CMPU = 5'h08,
                         O_PER  = 5'h0C, O_PERU = 5'h10;

  logic [NCH-1:0] run_q, stop_q, ev, flags_q;
  logic [3:0]     pre_q  [NCH];
  logic           pol_q  [NCH];
  logic [CW-1:0]  cmp_q  [NCH];
  logic [CW-1:0]  cmpu_q [NCH];
  logic [CW-1:0]  per_q  [NCH];
  logic [CW-1:0]  peru_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];

  logic          in_win;
  logic [AW-1:0] win_rel;
  logic [IW-1:0] win_idx;
  logic [4:0]    win_off;
  logic          wr_start, wr_stop, rd_evt;

  assign in_win   = (addr_i >= WIN_BASE) && (addr_i < WIN_END);
  assign win_rel  = addr_i - WIN_BASE;
  assign win_idx  = IW'(win_rel >> WIN_SH);
  assign win_off  = addr_i[4:0];
  assign wr_start = we_i && (addr_i == A_START);
  assign wr_stop  = we_i && (addr_i == A_STOP);
  assign rd_evt   = re_i && (addr_i == A_EVT);
  assign irq_o    = |flags_q;

  logic unused_hi;
  assign unused_hi = ^{wdata_i[DW-1:CW], win_rel[WIN_SH-1:0]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          wsel, start, tick, wrap;
    logic [3:0]    prec;
    logic [PW-1:0] psc_q, mask;

    assign wsel  = we_i && in_win && (win_idx == IW'(i));
    assign start = wr_start && wdata_i[i] && !run_q[i];
    assign prec  = (pre_q[i] > 4'(MAXPRE)) ? 4'(MAXPRE) : pre_q[i];
    assign mask  = (PW'(1) << prec) - PW'(1);
    assign tick  = run_q[i] && ((psc_q & mask) == mask);
    assign wrap  = tick && (({1'b0, cnt_q[i]} + 1'b1) >= {1'b0, per_q[i]});
    assign ev[i] = start || (wrap && !stop_q[i]);
    assign pwm_o[i] = pol_q[i] ^ (run_q[i] && (cnt_q[i] >= cmp_q[i]));

    logic cmpp_q, perp_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[i]  <= 1'b0;
        stop_q[i] <= 1'b0;
        psc_q     <= '0;
        cnt_q[i]  <= '0;
        pre_q[i]  <= '0;
        pol_q[i]  <= 1'b0;
        cmp_q[i]  <= '0;
        cmpu_q[i] <= '0;
        per_q[i]  <= '0;
        peru_q[i] <= '0;
        cmpp_q    <= 1'b0;
        perp_q    <= 1'b0;
      end else begin
        if (start) begin
          run_q[i]  <= 1'b1;
          stop_q[i] <= 1'b0;
          psc_q     <= '0;
          cnt_q[i]  <= '0;
          if (cmpp_q) begin cmp_q[i] <= cmpu_q[i]; cmpp_q <= 1'b0; end
          if (perp_q) begin per_q[i] <= peru_q[i]; perp_q <= 1'b0; end
        end else if (run_q[i]) begin
          psc_q <= psc_q + 1'b1;
          if (wr_stop && wdata_i[i]) stop_q[i] <= 1'b1;
          if (tick) begin
            if (wrap) begin
              cnt_q[i] <= '0;
              psc_q    <= '0;
              if (stop_q[i]) begin
                run_q[i]  <= 1'b0;
                stop_q[i] <= 1'b0;
              end else begin
                if (cmpp_q) begin cmp_q[i] <= cmpu_q[i]; cmpp_q <= 1'b0; end
                if (perp_q) begin per_q[i] <= peru_q[i]; perp_q <= 1'b0; end
              end
            end else begin
              cnt_q[i] <= cnt_q[i] + 1'b1;
            end
          end
        end
        if (wsel) begin
          case (win_off)
            O_MODE: begin pre_q[i] <= wdata_i[3:0]; pol_q[i] <= wdata_i[9]; end
            O_CMP:  cmp_q[i] <= wdata_i[CW-1:0];
            O_CMPU: begin cmpu_q[i] <= wdata_i[CW-1:0]; cmpp_q <= 1'b1; end
            O_PER:  per_q[i] <= wdata_i[CW-1:0];
            O_PERU: begin peru_q[i] <= wdata_i[CW-1:0]; perp_q <= 1'b1; end
            default: ;
          endcase
        end
      end
    end

    // R2
    stat_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_q[i]) |-> $past(stop_q[i]));

    // R1
    start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_start && wdata_i[i]) |=> run_q[i]);

    // R8
    idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q[i] |-> (pwm_o[i] == pol_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (rd_evt) flags_q <= ev;
    else             flags_q <= flags_q | ev;
  end

  // R4
  evt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && |ev) |=> ((flags_q & $past(ev)) == $past(ev)));

  // R5
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> irq_o);

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == A_STAT)     rdata_o = DW'(run_q);
      else if (addr_i == A_EVT) rdata_o = DW'(flags_q);
      else if (in_win) begin
        for (int k = 0; k < NCH; k++) begin
          if (win_idx == IW'(k)) begin
            case (win_off)
              O_MODE: rdata_o = DW'({pol_q[k], 5'b0, pre_q[k]});
              O_CMP:  rdata_o = DW'(cmp_q[k]);
              O_CMPU: rdata_o = DW'(cmpu_q[k]);
              O_PER:  rdata_o = DW'(per_q[k]);
              O_PERU: rdata_o = DW'(peru_q[k]);
              default: rdata_o = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: tb/pwm_regblk_tb.sv
module pwm_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  pwm;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_regblk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq), .pwm_o(pwm)
  );

  localparam int NV = 22;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 12'h200, 32'hFFFF_FFFF},
    {1'b0, 12'h200, 32'h0000_020F},
    {1'b1, 12'h224, 32'h1234_5678},
    {1'b0, 12'h224, 32'h0000_5678},
    {1'b1, 12'h24C, 32'h0000_ABCD},
    {1'b0, 12'h24C, 32'h0000_ABCD},
    {1'b1, 12'h270, 32'h0000_0055},
    {1'b0, 12'h270, 32'h0000_0055},
    {1'b0, 12'h26C, 32'h0000_0000},
    {1'b1, 12'h268, 32'h0000_0099},
    {1'b0, 12'h268, 32'h0000_0099},
    {1'b0, 12'h264, 32'h0000_0000},
    {1'b1, 12'h204, 32'h0000_0042},
    {1'b1, 12'h284, 32'h0000_7777},
    {1'b1, 12'h205, 32'h0000_1111},
    {1'b0, 12'h204, 32'h0000_0042},
    {1'b0, 12'h284, 32'h0000_0000},
    {1'b0, 12'h100, 32'h0000_0000},
    {1'b0, 12'h214, 32'h0000_0000},
    {1'b0, 12'h205, 32'h0000_0000},
    {1'b0, 12'h00C, 32'h0000_0000},
    {1'b0, 12'h01C, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int hi, edges;
    logic prev;
    @(negedge clk);
    do_reset();

    // R1 R5 R8 reset state
    rd(12'h00C, v); check("R1 reset status", v, 0);
    check("R5 reset irq", {31'b0, irq}, 0);
    check("R8 reset outputs", {28'b0, pwm}, 0);

    // R6 R9 register map table
    for (int n = 0; n < NV; n++) begin
      if (VEC[n][44]) wr(VEC[n][43:32], VEC[n][31:0]);
      else begin
        rd(VEC[n][43:32], v);
        check($sformatf("R6/R9 vector %0d", n), v, VEC[n][31:0]);
      end
    end
    do_reset();

    // R1 R3 R5: slow channel 1 (prescale 10, period 2 -> 2048 clocks)
    wr(12'h220, 32'h0000_000A);
    wr(12'h22C, 32'h2);
    wr(12'h224, 32'h1);
    wr(12'h004, 32'h0);
    rd(12'h00C, v); check("R1 zero start bits ignored", v, 0);
    wr(12'h004, 32'h2);
    rd(12'h00C, v); check("R1 status after start", v, 32'h2);
    check("R5 irq set", {31'b0, irq}, 1);
    rd(12'h01C, v); check("R3 event flag read", v, 32'h2);
    rd(12'h01C, v); check("R3 flags cleared by read", v, 0);
    check("R5 irq cleared", {31'b0, irq}, 0);
    wr(12'h008, 32'h0);
    rd(12'h00C, v); check("R2 zero stop bits ignored", v, 32'h2);

    // R7 shadow registers on the slow channel
    wr(12'h228, 32'h7);
    wr(12'h230, 32'h3);
    rd(12'h224, v); check("R7 compare held", v, 32'h1);
    rd(12'h22C, v); check("R7 period held", v, 32'h2);
    repeat (2100) @(negedge clk);
    rd(12'h224, v); check("R7 compare applied", v, 32'h7);
    rd(12'h22C, v); check("R7 period applied", v, 32'h3);
    rd(12'h01C, v); check("R3 boundary event", v, 32'h2);

    // R2 stop lags to end of period, channel 0 period 8
    wr(12'h20C, 32'h8);
    wr(12'h204, 32'h4);
    wr(12'h004, 32'h1);
    repeat (3) @(negedge clk);
    wr(12'h008, 32'h1);
    rd(12'h00C, v); check("R2 status still running", v & 32'h1, 32'h1);
    repeat (12) @(negedge clk);
    rd(12'h00C, v); check("R2 status cleared later", v & 32'h1, 32'h0);
    check("R8 stopped output inactive", {31'b0, pwm[0]}, 0);

    // R8 duty and polarity, channel 2 period 4 compare 1
    wr(12'h24C, 32'h4);
    wr(12'h244, 32'h1);
    wr(12'h004, 32'h4);
    repeat (5) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 40; k++) begin hi += pwm[2]; @(negedge clk); end
    check("R8 high count polarity 0", hi, 30);
    wr(12'h240, 32'h200);
    @(negedge clk);
    hi = 0;
    for (int k = 0; k < 40; k++) begin hi += pwm[2]; @(negedge clk); end
    check("R8 high count polarity 1", hi, 10);

    // R8 prescale: code 1 doubles the period
    wr(12'h240, 32'h1);
    wr(12'h244, 32'h2);
    repeat (10) @(negedge clk);
    edges = 0; prev = pwm[2];
    for (int k = 0; k < 80; k++) begin
      if (pwm[2] && !prev) edges++;
      prev = pwm[2];
      @(negedge clk);
    end
    check("R8 prescaled edge count", (edges >= 9 && edges <= 11) ? 10 : edges, 10);

    // R4 coincident event kept: channel 3 period 1 events every clock
    wr(12'h26C, 32'h1);
    wr(12'h004, 32'h8);
    rd(12'h01C, v); check("R3 fast channel flag", v & 32'h8, 32'h8);
    rd(12'h01C, v); check("R4 flag survives read", v & 32'h8, 32'h8);
    check("R5 irq held", {31'b0, irq}, 1);
    wr(12'h004, 32'h8);
    rd(12'h00C, v); check("R1 restart of running ignored", v & 32'h8, 32'h8);

    finish_up();
  end
endmodule